// File: doc/BRIEF.md
# Two-Source Byte Permute Unit

This block assembles a 128-bit result vector byte by byte. Each result byte is chosen from a 32-byte pool made of two 128-bit source vectors, and a 128-bit control vector supplies one index byte per result byte. One operation can therefore split interleaved records into separate streams, merge two streams back into one, reverse byte order, or apply any other byte reordering, without a fixed shift or rotate network.

Operands enter through a valid/ready handshake. In the default registered mode the result is held in one output register until the consumer takes it. A parameter selects a purely combinational variant instead. Byte 0 is the leftmost, most significant byte of every vector. The leftmost 32-bit word (bytes 0 to 3) is the scalar slot.

Top module: `byte_permute_unit`

## Requirements
- R1: Byte n of a vector is bits [127-8n : 120-8n], so byte 0 is the most significant byte. Result byte n is set by control byte n.
- R2: A control byte whose 5-bit index (bits 4:0) is 0 to 15 copies that byte of src_a. An index of 16 to 31 copies byte (index-16) of src_b.
- R3: Control bits 6:5 take no part in selection. A control byte with those bits set gives the same result byte as the same byte with them clear.
- R4: A control byte with bit 7 set gives 0x00 in that result byte, whatever its other bits are.
- R5: A transfer is accepted when in_valid and in_ready are both high at a clock edge. The permuted value then appears on res_data after that same edge, with res_valid high.
- R6: Reset, asserted at any time, clears res_valid at once.
- R7: While res_valid is high and res_ready is low, res_valid and res_data hold their values.
- R8: in_ready is high exactly when the output register is empty or is being emptied in the same cycle (res_ready high).
- R9: The control pattern with word starts 0, 8, 16, 24 gives the first and third words of src_a followed by the first and third words of src_b. This extracts the real parts of interleaved complex pairs.
- R10: The control pattern with word starts 4, 12, 20, 28 gives the second and fourth words of each source. This extracts the imaginary parts.
- R11: The word-start patterns 0, 16, 4, 20 (high merge) and 8, 24, 12, 28 (low merge) interleave words of src_a and src_b alternately.
- R12: Arbitrary control vectors, including out-of-range and zeroing bytes, match a byte-level reference under random valid and ready traffic.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operands and control are valid |
| in_ready | output | 1 | Unit can accept an operand set this cycle |
| src_a | input | 128 | First source vector (pool bytes 0 to 15) |
| src_b | input | 128 | Second source vector (pool bytes 16 to 31) |
| ctrl | input | 128 | One index byte per result byte |
| res_data | output | 128 | Permuted result |
| res_valid | output | 1 | res_data holds a result |
| res_ready | input | 1 | Consumer takes the result this cycle |

## Verification
The bound checker watches the handshake on every cycle. It checks that an accepted transfer produces a valid result on the next edge, that a stalled result holds, that in_ready drops while a result is stalled, and that reset empties the output. It also checks, lane by lane, that a control byte with bit 7 set yields a zero result byte. The byte-level selection requires the bench's reference model: identity and reversed patterns, the four complex-data patterns, ignored index bits, and random control vectors under random backpressure.

// File: rtl/bperm_pkg.sv
package bperm_pkg;

    // Default geometry: 16 lanes of 8-bit bytes (128-bit vectors)
    localparam int LANES_DFLT  = 16;
    localparam int BYTE_W_DFLT = 8;

    // What one result lane does, decoded from its control byte
    typedef enum logic [1:0] {
        LANE_PICK_A = 2'd0,
        LANE_PICK_B = 2'd1,
        LANE_ZERO   = 2'd2
    } lane_act_e;

endpackage

// File: rtl/bperm_lane.sv
module bperm_lane #(
    parameter int LANES  = bperm_pkg::LANES_DFLT,
    parameter int BYTE_W = bperm_pkg::BYTE_W_DFLT
) (
    input  logic [LANES*BYTE_W-1:0] src_a,
    input  logic [LANES*BYTE_W-1:0] src_b,
    input  logic [BYTE_W-1:0]       sel_byte,
    output logic [BYTE_W-1:0]       lane_out
);
    import bperm_pkg::*;

    localparam int VEC_W = LANES * BYTE_W;
    localparam int OFF_W = $clog2(LANES);
    localparam int IDX_W = OFF_W + 1;

    // Byte k sits in the k-th byte from the most significant end
    logic [BYTE_W-1:0] a_bytes [LANES];
    logic [BYTE_W-1:0] b_bytes [LANES];

    for (genvar k = 0; k < LANES; k++) begin : g_split
        assign a_bytes[k] = src_a[VEC_W-1-k*BYTE_W -: BYTE_W];
        assign b_bytes[k] = src_b[VEC_W-1-k*BYTE_W -: BYTE_W];
    end

    // Index bits that take no part in selection
    if (BYTE_W - 2 >= IDX_W) begin : g_spare
        logic lane_unused_bits;
        assign lane_unused_bits = ^sel_byte[BYTE_W-2:IDX_W];
    end

    lane_act_e         act;
    logic [OFF_W-1:0]  off;

    always_comb begin
        off = sel_byte[OFF_W-1:0];
        if (sel_byte[BYTE_W-1]) begin
            act = LANE_ZERO;
        end else if (sel_byte[IDX_W-1]) begin
            act = LANE_PICK_B;
        end else begin
            act = LANE_PICK_A;
        end
    end

    always_comb begin
        unique case (act)
            LANE_PICK_A: lane_out = a_bytes[off];
            LANE_PICK_B: lane_out = b_bytes[off];
            default:     lane_out = '0;
        endcase
    end

endmodule

// File: rtl/bperm_xbar.sv
module bperm_xbar #(
    parameter int LANES  = bperm_pkg::LANES_DFLT,
    parameter int BYTE_W = bperm_pkg::BYTE_W_DFLT
) (
    input  logic [LANES*BYTE_W-1:0] src_a,
    input  logic [LANES*BYTE_W-1:0] src_b,
    input  logic [LANES*BYTE_W-1:0] ctrl,
    output logic [LANES*BYTE_W-1:0] perm
);
    localparam int VEC_W = LANES * BYTE_W;

    for (genvar n = 0; n < LANES; n++) begin : g_lane
        bperm_lane #(
            .LANES  (LANES),
            .BYTE_W (BYTE_W)
        ) u_lane (
            .src_a    (src_a),
            .src_b    (src_b),
            .sel_byte (ctrl[VEC_W-1-n*BYTE_W -: BYTE_W]),
            .lane_out (perm[VEC_W-1-n*BYTE_W -: BYTE_W])
        );
    end

endmodule

// File: rtl/byte_permute_unit.sv
module byte_permute_unit #(
    parameter int LANES   = bperm_pkg::LANES_DFLT,
    parameter int BYTE_W  = bperm_pkg::BYTE_W_DFLT,
    parameter bit REG_OUT = 1'b1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    output logic                    in_ready,
    input  logic [LANES*BYTE_W-1:0] src_a,
    input  logic [LANES*BYTE_W-1:0] src_b,
    input  logic [LANES*BYTE_W-1:0] ctrl,
    output logic [LANES*BYTE_W-1:0] res_data,
    output logic                    res_valid,
    input  logic                    res_ready
);
    localparam int VEC_W = LANES * BYTE_W;

    logic [VEC_W-1:0] perm_w;

    bperm_xbar #(
        .LANES  (LANES),
        .BYTE_W (BYTE_W)
    ) u_xbar (
        .src_a (src_a),
        .src_b (src_b),
        .ctrl  (ctrl),
        .perm  (perm_w)
    );

    if (REG_OUT) begin : g_reg
        typedef struct packed {
            logic             vld;
            logic [VEC_W-1:0] data;
        } stage_t;

        stage_t stage_d;
        stage_t stage_q;
        logic   drain;
        logic   take;

        always_comb begin
            stage_d = stage_q;
            drain   = stage_q.vld && res_ready;
            take    = in_valid && (!stage_q.vld || res_ready);
            if (drain) begin
                stage_d.vld = 1'b0;
            end
            if (take) begin
                stage_d.vld  = 1'b1;
                stage_d.data = perm_w;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                stage_q <= '0;
            end else begin
                stage_q <= stage_d;
            end
        end

        assign in_ready  = !stage_q.vld || res_ready;
        assign res_valid = stage_q.vld;
        assign res_data  = stage_q.data;
    end else begin : g_comb
        logic comb_unused_clk;
        assign comb_unused_clk = clk ^ rst_n;
        assign in_ready  = res_ready;
        assign res_valid = in_valid;
        assign res_data  = perm_w;
    end

endmodule

// File: rtl/byte_permute_unit_sva.sv
module byte_permute_unit_sva #(
    parameter int LANES   = bperm_pkg::LANES_DFLT,
    parameter int BYTE_W  = bperm_pkg::BYTE_W_DFLT,
    parameter bit REG_OUT = 1'b1
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    in_valid,
    input logic                    in_ready,
    input logic [LANES*BYTE_W-1:0] ctrl,
    input logic [LANES*BYTE_W-1:0] res_data,
    input logic                    res_valid,
    input logic                    res_ready
);
    localparam int VEC_W = LANES * BYTE_W;

    logic accepted;
    assign accepted = in_valid && in_ready;

    if (REG_OUT) begin : g_chk
        // R5: accepted transfer yields a valid result after the edge
        assert_accept_valid_R5: assert property (@(posedge clk) disable iff (!rst_n)
            accepted |=> res_valid);

        // R7: a stalled result holds
        assert_stall_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (res_valid && !res_ready) |=> (res_valid && $stable(res_data)));

        // R8: no new operands while a result is stalled
        assert_stall_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (res_valid && !res_ready) |-> !in_ready);

        // R6: reset empties the output
        assert_reset_empty_R6: assert property (@(posedge clk)
            !rst_n |-> !res_valid);

        // R4: a lane whose control byte has its top bit set produces zero
        for (genvar l = 0; l < LANES; l++) begin : g_zero
            assert_zero_lane_R4: assert property (@(posedge clk) disable iff (!rst_n)
                (accepted && ctrl[VEC_W-1-l*BYTE_W]) |=>
                    (res_data[VEC_W-1-l*BYTE_W -: BYTE_W] == '0));
        end
    end

endmodule

bind byte_permute_unit byte_permute_unit_sva #(
    .LANES   (LANES),
    .BYTE_W  (BYTE_W),
    .REG_OUT (REG_OUT)
) u_sva (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .ctrl      (ctrl),
    .res_data  (res_data),
    .res_valid (res_valid),
    .res_ready (res_ready)
);

// File: tb/byte_permute_unit_bench.sv
`timescale 1ns/1ps
module byte_permute_unit_bench;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic         in_ready;
    logic [127:0] src_a = '0;
    logic [127:0] src_b = '0;
    logic [127:0] ctrl = '0;
    logic [127:0] res_data;
    logic         res_valid;
    logic         res_ready = 1'b1;

    always #10 clk = ~clk;

    byte_permute_unit u_byte_permute_unit (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .src_a     (src_a),
        .src_b     (src_b),
        .ctrl      (ctrl),
        .res_data  (res_data),
        .res_valid (res_valid),
        .res_ready (res_ready)
    );

    int           n_checks = 0;
    int           n_fails  = 0;
    bit           finished = 1'b0;

    // Reference state: at most one result pending
    bit           pend_v = 1'b0;
    logic [127:0] pend_d = '0;
    string        pend_tag = "";

    function automatic logic [127:0] ref_perm(logic [127:0] a, logic [127:0] b, logic [127:0] c);
        logic [127:0] r = '0;
        for (int i = 0; i < 16; i++) begin
            int sel = int'(c[127-8*i -: 8]);
            int k;
            logic [7:0] v;
            if (sel >= 128) begin
                v = 8'h00;
            end else begin
                k = sel % 32;
                if (k < 16) v = a[127-8*k -: 8];
                else        v = b[127-8*(k-16) -: 8];
            end
            r[127-8*i -: 8] = v;
        end
        return r;
    endfunction

    function automatic logic [127:0] word_pattern(int s0, int s1, int s2, int s3);
        logic [127:0] c = '0;
        int starts [4] = '{s0, s1, s2, s3};
        for (int w = 0; w < 4; w++) begin
            for (int j = 0; j < 4; j++) begin
                c[127-8*(4*w+j) -: 8] = 8'(starts[w] + j);
            end
        end
        return c;
    endfunction

    function automatic logic [127:0] rnd128();
        return {$urandom, $urandom, $urandom, $urandom};
    endfunction

    task automatic check_bit(string tag, logic act, logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: got %b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic check_vec(string tag, logic [127:0] act, logic [127:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: got %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    // One cycle: check outputs settled after the last edge, then drive the next inputs
    task automatic step(bit v, logic [127:0] a, logic [127:0] b, logic [127:0] c, bit rdy, string tag);
        bit exp_ready;
        @(negedge clk);
        check_bit({tag, " res_valid (R5)"}, res_valid, pend_v);
        if (pend_v) check_vec({pend_tag, " res_data"}, res_data, pend_d);
        in_valid  = v;
        src_a     = a;
        src_b     = b;
        ctrl      = c;
        res_ready = rdy;
        #1;
        exp_ready = !pend_v || rdy;
        check_bit({tag, " in_ready (R8)"}, in_ready, exp_ready);
        if (pend_v && rdy) pend_v = 1'b0;
        if (v && exp_ready) begin
            pend_v   = 1'b1;
            pend_d   = ref_perm(a, b, c);
            pend_tag = tag;
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    endtask

    initial begin
        #(20 * 150000);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: run did not complete, got timeout expected completion");
        finish_run();
    end

    initial begin
        logic [127:0] a;
        logic [127:0] b;
        logic [127:0] c;
        logic [127:0] ident;
        logic [127:0] rev;

        // R6: reset state
        repeat (3) @(negedge clk);
        check_bit("R6 reset res_valid", res_valid, 1'b0);
        check_bit("R8 reset in_ready", in_ready, 1'b1);
        rst_n = 1'b1;

        a = 128'h00112233_44556677_8899AABB_CCDDEEFF;
        b = 128'hF0E1D2C3_B4A59687_78695A4B_3C2D1E0F;
        for (int i = 0; i < 16; i++) begin
            ident[127-8*i -: 8] = 8'(i);
            rev[127-8*i -: 8]   = 8'(15 - i);
        end

        // R1: identity and reversal show byte numbering
        step(1, a, b, ident, 1, "R1 identity");
        step(1, a, b, rev, 1, "R1 reversed");
        // R2: second source through indices 16..31
        step(1, a, b, ident | {16{8'h10}}, 1, "R2 src_b identity");
        step(1, a, b, {8'd31, 8'd0, 8'd16, 8'd15, {12{8'd20}}}, 1, "R2 boundaries");
        // R3: bits 6:5 ignored
        step(1, a, b, ident | {16{8'h60}}, 1, "R3 spare bits");
        step(1, a, b, rev | {16{8'h30}}, 1, "R3 spare bits src_b");
        // R4: top bit zeroes the lane
        step(1, a, b, {{8{8'h80}}, {8{8'hFF}}}, 1, "R4 zero lanes");
        step(1, a, b, {8'h85, 8'd1, 8'h9F, 8'd17, 8'hC0, 8'd2, 8'hE3, 8'd3, {8{8'd5}}}, 1, "R4 mixed");

        // Complex-data patterns with word-tagged sources
        a = 128'hA0A0A0A0_A1A1A1A1_A2A2A2A2_A3A3A3A3;
        b = 128'hB0B0B0B0_B1B1B1B1_B2B2B2B2_B3B3B3B3;
        step(1, a, b, word_pattern(0, 8, 16, 24), 1, "R9 real extract");
        step(1, a, b, word_pattern(4, 12, 20, 28), 1, "R10 imag extract");
        step(1, a, b, word_pattern(0, 16, 4, 20), 1, "R11 merge high");
        step(1, a, b, word_pattern(8, 24, 12, 28), 1, "R11 merge low");
        step(0, a, b, '0, 1, "drain");
        // Explicit word-level expectation for the real-part gather (R9)
        check_vec("R9 model agrees", ref_perm(a, b, word_pattern(0, 8, 16, 24)),
                  128'hA0A0A0A0_A2A2A2A2_B0B0B0B0_B2B2B2B2);

        // R7: result holds under backpressure while new operands wait
        step(1, a, b, rev, 0, "R7 stall load");
        for (int k = 0; k < 4; k++) step(1, rnd128(), rnd128(), rnd128(), 0, "R7 stall hold");
        step(0, a, b, '0, 1, "R7 release");
        step(0, a, b, '0, 1, "drain");

        // R12: random traffic
        for (int k = 0; k < 400; k++) begin
            step(($urandom % 4) != 0, rnd128(), rnd128(), rnd128(), ($urandom % 3) != 0, "R12 random");
        end

        // R6: reset mid-run with a stalled result
        step(1, a, b, ident, 0, "R6 preload");
        step(0, a, b, ident, 0, "R6 preload hold");
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        check_bit("R6 async clear", res_valid, 1'b0);
        pend_v = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        step(1, b, a, rev, 1, "R5 after reset");
        step(0, a, b, '0, 1, "drain");
        step(0, a, b, '0, 1, "drain");

        finish_run();
    end

endmodule